// File: doc/BRIEF.md
# Floating-Point Exception Priority Resolver

This block makes the final exception decision for one single-precision add, subtract, multiply or divide lane. An upstream datapath computes the operation and hands over the two operand encodings, its raw status flags, and the result in a wide-exponent form: sign, unbiased exponent, 24-bit significand with the hidden bit, and markers for a NaN or infinite result. Together with six exception masks and the flush-to-zero and denormals-as-zero controls, the resolver decides whether a trap must be raised. It also picks the cause and forms the six status flags and the 32-bit result to deliver.

Faults are tested first: invalid, NaN operands, denormal operand, divide-by-zero. Traps follow: underflow, overflow, inexact. The first test that fires decides the outcome. On an underflow or overflow trap, the delivered exponent is rebiased by 192 so that a handler receives a representable scaled value. Flush-to-zero replaces tiny results with signed zeros and feeds into the inexact and underflow reporting. The decision is registered and appears one cycle after a valid input, with its own valid strobe.

Top module: `fp_trap_resolver`

## Requirements
- R1: All outputs reset to zero. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The other outputs load only on `in_valid` and hold otherwise.
- R2: Flag and mask vectors use bit 0 invalid, bit 1 denormal, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow and bit 5 inexact. A mask bit of 1 masks that exception. `out_cause` uses 0 none, 1 invalid, 2 denormal, 3 divide-by-zero, 4 overflow, 5 underflow and 6 inexact. `out_raise` is high exactly when the cause is nonzero.
- R3: With raw invalid set and invalid unmasked, the block raises cause 1 with only status bit 0 set. This has the highest priority.
- R4: Otherwise, if either operand is a NaN (exponent all ones, fraction nonzero), nothing is raised and the status is only the raw invalid bit. If both operands are NaNs, the result is operand A with fraction bit 22 forced to 1. Otherwise the result is the operation's NaN.
- R5: The effective denormal flag is raw denormal, cleared when raw divide-by-zero is set or when denormals-as-zero is set. If this flag is set and denormal is unmasked, the block raises cause 2 with only status bit 1.
- R6: Otherwise, with raw divide-by-zero set and divide-by-zero unmasked, the block raises cause 3 with only status bit 2.
- R7: Otherwise, a NaN result is delivered as {sign, 8'hFF, 1, significand[21:0]} with no raise and only status bit 0 set.
- R8: A result is tiny when it is nonzero, finite and its exponent is below -126. It is huge when it is finite and its exponent is above 127. A tiny result with underflow unmasked raises cause 5, with status underflow plus inexact if raw inexact is set. The delivered result is {sign, exponent+319, significand[22:0]}.
- R9: Otherwise, a huge result with overflow unmasked raises cause 4, with status overflow plus inexact if raw inexact is set. The delivered result is {sign, exponent-65, significand[22:0]}.
- R10: Otherwise, with inexact unmasked and either raw inexact set or flush-to-zero on with a tiny result, the block raises cause 6. The status is inexact, plus underflow if the result is tiny and overflow if it is huge. The delivered result is the bounded result of R12.
- R11: With flush-to-zero on, a tiny result is delivered as a zero carrying the result sign, and both inexact and underflow are reported.
- R12: When nothing is raised (outside R4 and R7), the status is the raw flags with the effective denormal of R5, ORed with the R11 flags. The bounded result is delivered: {sign, exponent+127, significand[22:0]} when normal, a signed infinity when infinite or huge, a signed zero for a zero significand, and for a tiny result {sign, 0, significand shifted right by (-126 - exponent)}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set is valid this cycle |
| op_a | input | 32 | First operand encoding |
| op_b | input | 32 | Second operand encoding |
| raw_flags | input | 6 | Raw status flags from the operation |
| res_sign | input | 1 | Result sign |
| res_exp | input | EXP_W | Unbiased result exponent, signed |
| res_sig | input | 24 | Result significand with hidden bit |
| res_nan | input | 1 | Result is a NaN |
| res_inf | input | 1 | Result is infinite |
| exc_mask | input | 6 | Exception masks, 1 = masked |
| ftz | input | 1 | Flush tiny results to zero |
| daz | input | 1 | Denormal operands were treated as zero |
| out_valid | output | 1 | Decision valid strobe |
| out_raise | output | 1 | A trap must be taken |
| out_cause | output | 3 | Encoded exception cause |
| out_status | output | 6 | Status flags to report |
| out_result | output | 32 | Delivered single-precision result |

## Verification
A wrong priority decision shows up at once as the wrong cause code, and usually a wrong status pattern as well, in the single output cycle that follows the input. The bench therefore sweeps every raw-flag and mask combination against each class of result, both signs of a tiny result, and both flush-to-zero settings. A fault in the tiny, huge or rebias logic shows up in `out_result` for the same cycle. A broken clock enable shows up as outputs that change during idle cycles.

// File: rtl/fp_trap_pkg.sv
package fp_trap_pkg;
  localparam int NFLAG = 6;
  localparam int F_INV = 0;
  localparam int F_DEN = 1;
  localparam int F_DZ  = 2;
  localparam int F_OVF = 3;
  localparam int F_UNF = 4;
  localparam int F_INX = 5;

  localparam int SIG_W   = 24;
  localparam int BIAS    = 127;
  localparam int REBIAS  = 192;
  localparam int EXP_MIN = -126;
  localparam int EXP_MAX = 127;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_INV  = 3'd1,
    CAUSE_DEN  = 3'd2,
    CAUSE_DZ   = 3'd3,
    CAUSE_OVF  = 3'd4,
    CAUSE_UNF  = 3'd5,
    CAUSE_INX  = 3'd6
  } cause_e;

  typedef struct packed {
    logic             raise;
    cause_e           cause;
    logic [NFLAG-1:0] status;
    logic [31:0]      result;
  } verdict_t;
endpackage

// File: rtl/fp_opnd_class.sv
module fp_opnd_class (
  input  logic [31:0] opnd,
  output logic        is_nan,
  output logic [31:0] quieted
);
  always_comb begin
    is_nan  = (opnd[30:23] == 8'hFF) && (opnd[22:0] != 23'd0);
    quieted = {opnd[31:23], 1'b1, opnd[21:0]};
  end
endmodule

// File: rtl/fp_result_class.sv
module fp_result_class
  import fp_trap_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [SIG_W-1:0]        sig,
  input  logic                    nan,
  input  logic                    inf,
  input  logic                    ftz,
  output logic                    tiny,
  output logic                    huge,
  output logic [31:0]             bounded,
  output logic [31:0]             scaled_up,
  output logic [31:0]             scaled_dn
);
  localparam int EW = EXP_W + 2;
  localparam logic signed [EW-1:0] LIM_LO  = EW'(EXP_MIN);
  localparam logic signed [EW-1:0] LIM_HI  = EW'(EXP_MAX);
  localparam logic signed [EW-1:0] K_BIAS  = EW'(BIAS);
  localparam logic signed [EW-1:0] K_UP    = EW'(BIAS + REBIAS);
  localparam logic signed [EW-1:0] K_DN    = EW'(BIAS - REBIAS);
  localparam logic signed [EW-1:0] SH_MAX  = EW'(SIG_W);

  logic signed [EW-1:0] e;
  logic signed [EW-1:0] shamt;
  logic signed [EW-1:0] e_b;
  logic signed [EW-1:0] e_up;
  logic signed [EW-1:0] e_dn;
  logic [SIG_W-1:0]     den;
  logic                 is_zero;
  logic                 finite;

  always_comb begin
    e       = {{2{exp_in[EXP_W-1]}}, exp_in};
    finite  = !nan && !inf;
    is_zero = finite && (sig == '0);
    tiny    = finite && !is_zero && (e < LIM_LO);
    huge    = finite && !is_zero && (e > LIM_HI);
    shamt   = LIM_LO - e;
    e_b     = e + K_BIAS;
    e_up    = e + K_UP;
    e_dn    = e + K_DN;
    if (shamt >= SH_MAX) den = '0;
    else                 den = sig >> shamt[4:0];

    if (nan)                bounded = {sign, 8'hFF, 1'b1, sig[21:0]};
    else if (inf || huge)   bounded = {sign, 8'hFF, 23'd0};
    else if (is_zero)       bounded = {sign, 31'd0};
    else if (tiny)          bounded = ftz ? {sign, 31'd0} : {sign, 8'h00, den[22:0]};
    else                    bounded = {sign, e_b[7:0], sig[22:0]};

    scaled_up = {sign, e_up[7:0], sig[22:0]};
    scaled_dn = {sign, e_dn[7:0], sig[22:0]};
  end
endmodule

// File: rtl/fp_trap_decide.sv
module fp_trap_decide
  import fp_trap_pkg::*;
(
  input  logic [NFLAG-1:0] raw,
  input  logic [NFLAG-1:0] mask,
  input  logic             ftz,
  input  logic             daz,
  input  logic             nan_a,
  input  logic             nan_b,
  input  logic [31:0]      quiet_a,
  input  logic             res_nan,
  input  logic             tiny,
  input  logic             huge,
  input  logic [31:0]      bounded,
  input  logic [31:0]      scaled_up,
  input  logic [31:0]      scaled_dn,
  output verdict_t         verdict
);
  logic [NFLAG-1:0] eff;
  logic [NFLAG-1:0] en;
  logic             flush;

  always_comb begin
    eff        = raw;
    eff[F_DEN] = raw[F_DEN] && !raw[F_DZ] && !daz;
    en         = ~mask;
    flush      = ftz && tiny;

    verdict.raise  = 1'b0;
    verdict.cause  = CAUSE_NONE;
    verdict.status = eff;
    verdict.result = bounded;
    if (flush) begin
      verdict.status[F_INX] = 1'b1;
      verdict.status[F_UNF] = 1'b1;
    end

    if (en[F_INV] && raw[F_INV]) begin
      verdict.raise  = 1'b1;
      verdict.cause  = CAUSE_INV;
      verdict.status = '0;
      verdict.status[F_INV] = 1'b1;
    end else if (nan_a || nan_b) begin
      verdict.status = '0;
      verdict.status[F_INV] = raw[F_INV];
      if (nan_a && nan_b) verdict.result = quiet_a;
    end else if (en[F_DEN] && eff[F_DEN]) begin
      verdict.raise  = 1'b1;
      verdict.cause  = CAUSE_DEN;
      verdict.status = '0;
      verdict.status[F_DEN] = 1'b1;
    end else if (en[F_DZ] && raw[F_DZ]) begin
      verdict.raise  = 1'b1;
      verdict.cause  = CAUSE_DZ;
      verdict.status = '0;
      verdict.status[F_DZ] = 1'b1;
    end else if (res_nan) begin
      verdict.status = '0;
      verdict.status[F_INV] = 1'b1;
    end else if (en[F_UNF] && tiny) begin
      verdict.raise  = 1'b1;
      verdict.cause  = CAUSE_UNF;
      verdict.status = '0;
      verdict.status[F_UNF] = 1'b1;
      verdict.status[F_INX] = raw[F_INX];
      verdict.result = scaled_up;
    end else if (en[F_OVF] && huge) begin
      verdict.raise  = 1'b1;
      verdict.cause  = CAUSE_OVF;
      verdict.status = '0;
      verdict.status[F_OVF] = 1'b1;
      verdict.status[F_INX] = raw[F_INX];
      verdict.result = scaled_dn;
    end else if (en[F_INX] && (raw[F_INX] || flush)) begin
      verdict.raise  = 1'b1;
      verdict.cause  = CAUSE_INX;
      verdict.status = '0;
      verdict.status[F_INX] = 1'b1;
      verdict.status[F_UNF] = tiny;
      verdict.status[F_OVF] = huge;
    end
  end
endmodule

// File: rtl/fp_trap_resolver.sv
module fp_trap_resolver
  import fp_trap_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [31:0]             op_a,
  input  logic [31:0]             op_b,
  input  logic [NFLAG-1:0]        raw_flags,
  input  logic                    res_sign,
  input  logic signed [EXP_W-1:0] res_exp,
  input  logic [SIG_W-1:0]        res_sig,
  input  logic                    res_nan,
  input  logic                    res_inf,
  input  logic [NFLAG-1:0]        exc_mask,
  input  logic                    ftz,
  input  logic                    daz,
  output logic                    out_valid,
  output logic                    out_raise,
  output logic [2:0]              out_cause,
  output logic [NFLAG-1:0]        out_status,
  output logic [31:0]             out_result
);
  localparam int NOPND = 2;

  logic [31:0]      opnd    [NOPND];
  logic [NOPND-1:0] opnd_nan;
  logic [31:0]      opnd_q  [NOPND];
  logic             tiny, huge;
  logic [31:0]      bounded, scaled_up, scaled_dn;
  verdict_t         verdict_d, verdict_q;
  logic             valid_q;

  always_comb begin
    opnd[0] = op_a;
    opnd[1] = op_b;
  end

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    fp_opnd_class u_cls (
      .opnd    (opnd[g]),
      .is_nan  (opnd_nan[g]),
      .quieted (opnd_q[g])
    );
  end

  fp_result_class #(.EXP_W(EXP_W)) u_res (
    .sign      (res_sign),
    .exp_in    (res_exp),
    .sig       (res_sig),
    .nan       (res_nan),
    .inf       (res_inf),
    .ftz       (ftz),
    .tiny      (tiny),
    .huge      (huge),
    .bounded   (bounded),
    .scaled_up (scaled_up),
    .scaled_dn (scaled_dn)
  );

  fp_trap_decide u_dec (
    .raw       (raw_flags),
    .mask      (exc_mask),
    .ftz       (ftz),
    .daz       (daz),
    .nan_a     (opnd_nan[0]),
    .nan_b     (opnd_nan[1]),
    .quiet_a   (opnd_q[0]),
    .res_nan   (res_nan),
    .tiny      (tiny),
    .huge      (huge),
    .bounded   (bounded),
    .scaled_up (scaled_up),
    .scaled_dn (scaled_dn),
    .verdict   (verdict_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) verdict_q <= verdict_d;
    end
  end

  always_comb begin
    out_valid  = valid_q;
    out_raise  = verdict_q.raise;
    out_cause  = verdict_q.cause;
    out_status = verdict_q.status;
    out_result = verdict_q.result;
  end
endmodule

// File: rtl/fp_trap_resolver_chk.sv
module fp_trap_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [5:0]  exc_mask,
  input logic        out_valid,
  input logic        out_raise,
  input logic [2:0]  out_cause,
  input logic [5:0]  out_status,
  input logic [31:0] out_result
);
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_result) && $stable(out_status) && $stable(out_raise)));

  a_r2_raise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_raise == (out_cause != 3'd0));

  a_r3_fault_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_raise && (out_cause inside {3'd1, 3'd2, 3'd3})) |-> ($countones(out_status) == 1));

  a_r8_unf_trap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_raise && out_cause == 3'd5) |-> (out_status[4] && !out_status[3]));

  a_r12_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && $past(exc_mask) == 6'h3F) |-> !out_raise);
endmodule

bind fp_trap_resolver fp_trap_resolver_chk u_chk (.*);

// File: tb/fp_trap_resolver_bench.sv
module fp_trap_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [5:0]  raw_flags, exc_mask;
  logic        res_sign, res_nan, res_inf, ftz, daz;
  logic signed [9:0] res_exp;
  logic [23:0] res_sig;
  logic        out_valid, out_raise;
  logic [2:0]  out_cause;
  logic [5:0]  out_status;
  logic [31:0] out_result;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_trap_resolver u_fp_trap_resolver (.*);

  // result classes: 0 normal, 1 tiny+, 2 tiny-, 3 huge, 4 nan result, 5 zero
  logic        c_sign [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  int          c_exp  [6] = '{5, -130, -130, 130, 0, 0};
  logic [23:0] c_sig  [6] = '{24'hA00000, 24'hC00000, 24'hC00000, 24'h800000, 24'hC00000, 24'h000000};
  logic [31:0] c_bnd  [6] = '{32'hC2200000, 32'h000C0000, 32'h800C0000, 32'h7F800000, 32'hFFC00000, 32'h80000000};
  logic [31:0] c_bftz [6] = '{32'hC2200000, 32'h00000000, 32'h80000000, 32'h7F800000, 32'hFFC00000, 32'h80000000};
  logic [31:0] c_up   [6] = '{32'h0, 32'h5EC00000, 32'hDEC00000, 32'h0, 32'h0, 32'h0};
  logic [31:0] c_dn   [6] = '{32'h0, 32'h0, 32'h0, 32'h20800000, 32'h0, 32'h0};

  task automatic check(input string tag, input logic [2:0] ec, input logic [5:0] es,
                       input logic [31:0] er);
    n_run++;
    if (out_valid !== 1'b1 || out_raise !== (ec != 3'd0) || out_cause !== ec ||
        out_status !== es || out_result !== er) begin
      n_fail++;
      $display("FAIL %s: got v=%0b r=%0b c=%0d s=%b res=%h exp c=%0d s=%b res=%h",
               tag, out_valid, out_raise, out_cause, out_status, out_result, ec, es, er);
    end
  endtask

  // Independent model of the priority list in the requirements.
  task automatic model(input int cls, input bit na, input bit nb, input logic [31:0] qa,
                       output string tag, output logic [2:0] ec, output logic [5:0] es,
                       output logic [31:0] er);
    bit tiny = (cls == 1 || cls == 2);
    bit huge = (cls == 3);
    bit dz = raw_flags[2];
    bit de = raw_flags[1] && !dz && !daz;
    bit fl = ftz && tiny;
    logic [31:0] bnd = fl ? c_bftz[cls] : c_bnd[cls];
    ec = 3'd0; er = bnd;
    es = {raw_flags[5] | fl, raw_flags[4] | fl, raw_flags[3], dz, de, raw_flags[0]};
    tag = "R12";
    if (!exc_mask[0] && raw_flags[0]) begin
      ec = 3'd1; es = 6'b000001; tag = "R3";
    end else if (na || nb) begin
      ec = 3'd0; es = {5'b0, raw_flags[0]}; tag = "R4";
      if (na && nb) er = qa;
    end else if (!exc_mask[1] && de) begin
      ec = 3'd2; es = 6'b000010; tag = "R5";
    end else if (!exc_mask[2] && dz) begin
      ec = 3'd3; es = 6'b000100; tag = "R6";
    end else if (cls == 4) begin
      es = 6'b000001; tag = "R7";
    end else if (!exc_mask[4] && tiny) begin
      ec = 3'd5; es = {raw_flags[5], 5'b10000}; er = c_up[cls]; tag = "R8";
    end else if (!exc_mask[3] && huge) begin
      ec = 3'd4; es = {raw_flags[5], 5'b01000}; er = c_dn[cls]; tag = "R9";
    end else if (!exc_mask[5] && (raw_flags[5] || fl)) begin
      ec = 3'd6; es = {1'b1, tiny, huge, 3'b000}; tag = "R10";
    end else if (fl) begin
      tag = "R11";
    end
  endtask

  task automatic apply(input int cls, input logic [31:0] a, input logic [31:0] b,
                       input bit na, input bit nb);
    string tag; logic [2:0] ec; logic [5:0] es; logic [31:0] er;
    in_valid = 1'b1;
    op_a = a; op_b = b;
    res_sign = c_sign[cls]; res_exp = 10'(c_exp[cls]); res_sig = c_sig[cls];
    res_nan = (cls == 4); res_inf = 1'b0;
    model(cls, na, nb, {a[31:23], 1'b1, a[21:0]}, tag, ec, es, er);
    @(negedge clk);
    check(tag, ec, es, er);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; raw_flags = '0; exc_mask = '0;
    res_sign = 0; res_exp = '0; res_sig = '0; res_nan = 0; res_inf = 0; ftz = 0; daz = 0;
    repeat (3) @(negedge clk);
    n_run++;
    if (out_valid !== 0 || out_raise !== 0 || out_cause !== 0 || out_status !== 0 || out_result !== 0) begin
      n_fail++;
      $display("FAIL R1: reset state v=%0b c=%0d s=%b res=%h exp all zero",
               out_valid, out_cause, out_status, out_result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2..R12: sweep flags x masks x result classes x flush-to-zero
    for (int f = 0; f < 2; f++)
      for (int cls = 0; cls < 6; cls++)
        for (int fl = 0; fl < 64; fl++)
          for (int m = 0; m < 64; m++) begin
            ftz = f[0]; daz = 1'b0; raw_flags = fl[5:0]; exc_mask = m[5:0];
            apply(cls, 32'h3F800000, 32'h40000000, 0, 0);
          end

    // R5: denormals-as-zero suppresses the denormal flag
    ftz = 1'b0; daz = 1'b1;
    for (int fl = 0; fl < 64; fl++)
      for (int m = 0; m < 64; m++) begin
        raw_flags = fl[5:0]; exc_mask = m[5:0];
        apply(0, 32'h3F800000, 32'h40000000, 0, 0);
      end
    daz = 1'b0;

    // R4: NaN operands (A signalling, B quiet, both)
    for (int p = 0; p < 3; p++)
      for (int fl = 0; fl < 64; fl++)
        for (int m = 0; m < 2; m++) begin
          raw_flags = fl[5:0]; exc_mask = m[0] ? 6'h3F : 6'h00;
          apply(4, (p != 1) ? 32'h7F800001 : 32'h3F800000,
                   (p != 0) ? 32'hFFC00123 : 32'h40000000, p != 1, p != 0);
        end

    // R1: outputs hold while in_valid is low
    raw_flags = 6'h00; exc_mask = 6'h3F;
    apply(0, 32'h3F800000, 32'h40000000, 0, 0);
    in_valid = 1'b0; res_sig = 24'h800000; res_exp = 10'sd1; raw_flags = 6'h3F; exc_mask = 6'h00;
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_result !== 32'hC2200000 || out_raise !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: idle hold v=%0b res=%h r=%0b exp v=0 res=c2200000 r=0",
               out_valid, out_result, out_raise);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule